// File: doc/BRIEF.md
# Limited-Range Output Clamp

This block sits at the end of a pixel pipeline and forces each of the three colour components of a 12-bit-per-component stream into a legal video range. A three-bit range code picks the limits: no limits at all, one of three fixed limited-range windows (8, 10 or 12 bit depth, scaled onto the 12-bit path), or a lower and upper bound that software sets separately for red, green and blue. An enable bit must also be set for any clamping to take place, so full-range output simply leaves the enable cleared.

Pixels arrive with a valid strobe and leave one clock later with the strobe delayed by the same amount. A four-word register port holds the control word and the three pairs of component bounds. Both the port and the pixel path run on one clock.

Top module: `range_clamp`

## Requirements
- R1: After reset out_valid is 0, all three outputs are 0, the control word reads 0, and every component bound word reads lower 0x010 and upper 0xFEF (word value 0x0FEF0010).
- R2: out_valid equals in_valid of the previous cycle.
- R3: While in_valid is 0, out_r, out_g and out_b keep their last values in the following cycle.
- R4: With the enable bit (control bit 0) cleared, or with range code 0, each output equals its input one cycle earlier.
- R5: With the enable set and range code 1, 2 or 3 (8-bit 16..235, 10-bit 64..940, 12-bit 256..3760, each scaled to 12 bits), every component is limited to 256..3760.
- R6: With the enable set and range code 7, each component is limited to its own programmed bounds: a value below the lower bound gives the lower bound, above the upper bound gives the upper bound, otherwise the value passes.
- R7: Range codes 4, 5 and 6 apply no limits, as code 0.
- R8: Register word 0 holds the enable in bit 0 and the range code in bits 3:1; words 1, 2 and 3 hold the red, green and blue bounds, lower in bits 11:0 and upper in bits 27:16. Writes occur when cfg_we is 1; cfg_rdata shows the addressed word combinationally, with all other bits 0.
- R9: When a programmed lower bound exceeds the upper bound, the lower-bound test takes priority: values below the lower bound give the lower bound, all others give the upper bound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 12 | Red component in |
| in_g | input | 12 | Green component in |
| in_b | input | 12 | Blue component in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red component out |
| out_g | output | 12 | Green component out |
| out_b | output | 12 | Blue component out |

## Verification
A wrong enable, range code or bound register shows at the ports on the very next valid pixel whose value lies outside the window, since the output is a registered function of the current input and the stored settings. The sweep therefore drives every 12-bit value through each component under all sixteen enable and code combinations, so a mis-decoded code or a swapped bound appears within a few pixels. Bound registers are also read back directly, and an inverted window exposes the compare priority.

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_r,
  input  logic [DW-1:0] in_g,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic [DW-1:0] out_r,
  output logic [DW-1:0] out_g,
  output logic [DW-1:0] out_b
);
  localparam int HI_LSB = 16;
  localparam logic [DW-1:0] LIM8_LO  = DW'(16  << (DW - 8));
  localparam logic [DW-1:0] LIM8_HI  = DW'(235 << (DW - 8));
  localparam logic [DW-1:0] LIM10_LO = DW'(64  << (DW - 10));
  localparam logic [DW-1:0] LIM10_HI = DW'(940 << (DW - 10));
  localparam logic [DW-1:0] LIM12_LO = DW'(256 << (DW - 12));
  localparam logic [DW-1:0] LIM12_HI = DW'(3760 << (DW - 12));
  localparam logic [DW-1:0] PRG_LO_RST = DW'(16);
  localparam logic [DW-1:0] PRG_HI_RST = DW'((1 << DW) - 17);

  logic          en_q;
  logic [2:0]    fmt_q;
  logic [DW-1:0] lo_q [3];
  logic [DW-1:0] hi_q [3];
  logic [1:0]    wsel;

  assign wsel = cfg_addr - 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fmt_q <= 3'd0;
      for (int c = 0; c < 3; c++) begin
        lo_q[c] <= PRG_LO_RST;
        hi_q[c] <= PRG_HI_RST;
      end
    end else if (cfg_we) begin
      if (cfg_addr == 2'd0) begin
        en_q  <= cfg_wdata[0];
        fmt_q <= cfg_wdata[3:1];
      end else begin
        lo_q[wsel] <= cfg_wdata[DW-1:0];
        hi_q[wsel] <= cfg_wdata[HI_LSB+DW-1:HI_LSB];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == 2'd0) begin
      cfg_rdata[0]   = en_q;
      cfg_rdata[3:1] = fmt_q;
    end else begin
      cfg_rdata[DW-1:0]               = lo_q[wsel];
      cfg_rdata[HI_LSB+DW-1:HI_LSB]   = hi_q[wsel];
    end
  end

  logic                active;
  logic [2:0][DW-1:0]  in_v, lo_v, hi_v, nxt_v;

  assign in_v = {in_b, in_g, in_r};

  always_comb begin
    active = en_q;
    for (int c = 0; c < 3; c++) begin
      lo_v[c] = lo_q[c];
      hi_v[c] = hi_q[c];
    end
    unique case (fmt_q)
      3'd1: for (int c = 0; c < 3; c++) begin lo_v[c] = LIM8_LO;  hi_v[c] = LIM8_HI;  end
      3'd2: for (int c = 0; c < 3; c++) begin lo_v[c] = LIM10_LO; hi_v[c] = LIM10_HI; end
      3'd3: for (int c = 0; c < 3; c++) begin lo_v[c] = LIM12_LO; hi_v[c] = LIM12_HI; end
      3'd7: ;
      default: active = 1'b0;
    endcase
  end

  for (genvar c = 0; c < 3; c++) begin : g_cmp
    assign nxt_v[c] = !active              ? in_v[c] :
                      (in_v[c] < lo_v[c])  ? lo_v[c] :
                      (in_v[c] > hi_v[c])  ? hi_v[c] : in_v[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_r <= nxt_v[0];
        out_g <= nxt_v[1];
        out_b <= nxt_v[2];
      end
    end
  end
endmodule

// File: rtl/range_clamp_chk.sv
module range_clamp_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_r,
  input logic [DW-1:0] in_g,
  input logic [DW-1:0] in_b,
  input logic          out_valid,
  input logic [DW-1:0] out_r,
  input logic [DW-1:0] out_g,
  input logic [DW-1:0] out_b,
  input logic          en,
  input logic [2:0]    fmt,
  input logic [DW-1:0] lo_r,
  input logic [DW-1:0] hi_r
);
  localparam logic [DW-1:0] FIX_LO = DW'(256 << (DW - 12));
  localparam logic [DW-1:0] FIX_HI = DW'(3760 << (DW - 12));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R3
  AST_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!en || fmt == 3'd0)) |=>
      (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b))); // R4
  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && en && fmt inside {3'd1, 3'd2, 3'd3}) |=>
      (out_g >= FIX_LO && out_g <= FIX_HI)); // R5
  AST_PROG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && en && fmt == 3'd7 && lo_r <= hi_r) |=>
      (out_r >= $past(lo_r) && out_r <= $past(hi_r))); // R6
  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt inside {3'd4, 3'd5, 3'd6}) |=> (out_b == $past(in_b))); // R7
  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && en && fmt == 3'd7 && in_r < lo_r) |=> (out_r == $past(lo_r))); // R9
endmodule

bind range_clamp range_clamp_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_r(in_r), .in_g(in_g), .in_b(in_b),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .en(en_q), .fmt(fmt_q), .lo_r(lo_q[0]), .hi_r(hi_q[0])
);

// File: tb/sim_range_clamp.sv
module sim_range_clamp;
  localparam int CLK_NS = 10;
  localparam int DW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid;
  logic [DW-1:0] out_r, out_g, out_b;

  int tests = 0, fails = 0;
  int lo [3] = '{16, 16, 16};
  int hi [3] = '{4079, 4079, 4079};
  bit cur_en = 0;
  int cur_code = 0;

  always #(CLK_NS/2) clk = ~clk;

  range_clamp #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(string rq, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int model(int v, int c);
    int l, h;
    if (!cur_en || !(cur_code inside {1, 2, 3, 7})) return v;
    if (cur_code == 7) begin l = lo[c]; h = hi[c]; end
    else begin l = 256; h = 3760; end
    if (v < l) return l;
    if (v > h) return h;
    return v;
  endfunction

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(string rq, int a, int exp);
    cfg_addr = 2'(a);
    #1;
    chk(rq, int'(cfg_rdata), exp);
  endtask

  task automatic pix(string rq, int r, int g, int b);
    in_valid = 1'b1; in_r = DW'(r); in_g = DW'(g); in_b = DW'(b);
    @(negedge clk);
    chk({rq, " valid"}, int'(out_valid), 1);
    chk({rq, " red"}, int'(out_r), model(r, 0));
    chk({rq, " green"}, int'(out_g), model(g, 1));
    chk({rq, " blue"}, int'(out_b), model(b, 2));
  endtask

  task automatic set_ctrl(bit e, int code);
    cur_en = e; cur_code = code;
    wr(0, (code << 1) | int'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_r", int'(out_r), 0);
    chk("R1 out_g", int'(out_g), 0);
    chk("R1 out_b", int'(out_b), 0);
    rd("R1 ctrl", 0, 0);
    for (int a = 1; a < 4; a++) rd("R1 bounds", a, 32'h0FEF0010);

    wr(0, -1);
    rd("R8 ctrl unused bits", 0, 32'hF);
    wr(2, 32'hFFFF_FFFF);
    rd("R8 green bounds", 2, 32'h0FFF0FFF);
    rd("R8 red untouched", 1, 32'h0FEF0010);
    wr(2, 32'h0FEF0010);

    for (int e = 0; e < 2; e++)
      for (int code = 0; code < 8; code++) begin
        string tag;
        set_ctrl(e[0], code);
        if (!e[0] || code == 0) tag = "R4";
        else if (code inside {4, 5, 6}) tag = "R7";
        else if (code == 7) tag = "R6";
        else tag = "R5";
        for (int v = 0; v < 4096; v++)
          pix(tag, v, 4095 - v, (v * 37 + 11) % 4096);
      end

    lo = '{100, 2000, 3000};
    hi = '{4000, 2100, 1000};
    wr(1, (4000 << 16) | 100);
    wr(2, (2100 << 16) | 2000);
    wr(3, (1000 << 16) | 3000);
    rd("R8 blue bounds", 3, (1000 << 16) | 3000);
    set_ctrl(1'b1, 7);
    for (int v = 0; v < 4096; v += 3) pix("R6 R9", v, v, v);

    pix("R3 last", 50, 2050, 3500);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b0; in_r = DW'(k); in_g = DW'(4000 - k); in_b = DW'(7 + k);
      @(negedge clk);
      chk("R2 valid low", int'(out_valid), 0);
      chk("R3 hold red", int'(out_r), 100);
      chk("R3 hold green", int'(out_g), 2050);
      chk("R3 hold blue", int'(out_b), 1000);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule